// File: doc/BRIEF.md
# Core and DMA Shared-Bus Arbiter with Wait-Timeout Escalation

This block decides, cycle by cycle, which of two requesters owns a single shared memory bus: the processor core or a DMA engine. Each side carries a programmable priority level. A DMA request whose level is strictly above the core's takes the bus at once. A request at the highest encodable level also takes it at once. In both cases the block raises a force-release signal toward the core and moves the grant on the next clock edge. A DMA request at a lower or equal level waits until the core goes idle.

A programmable wait limit bounds that wait. After the limit number of blocked cycles, the DMA request is promoted, and the core is forced off the bus. A limit of zero turns promotion off. The promotion lasts until the DMA request drops.

A memory-controller stall input holds the core for a fixed cycle count chosen by the operation kind. The stall always counts down to zero, even when the DMA takes the bus in the middle of it.

Top module: `core_dma_arbiter`

## Requirements
- R1: After reset, both grants, force-release, the promotion flag, the stall flag and the waiting flag are all low; at no time are both grants high together.
- R2: With the bus idle, a request is granted on the next edge. When both requesters ask at once, the DMA wins only if its level is strictly above the core's or equals the all-ones level; otherwise the core wins.
- R3: While the core owns the bus, a DMA request with a strictly higher level raises force-release combinationally in the same cycle, and the DMA grant appears on the next edge.
- R4: With the wait limit at zero, a DMA request at a level not above the core's (and not all-ones) is never promoted. It is granted on the edge after the core becomes idle, meaning its request is low and no stall is running.
- R5: With a wait limit T greater than zero, a blocked DMA request sets the promotion flag on the T-th edge after it is first seen blocked, and it receives the grant on edge T+1.
- R6: Dropping the DMA request clears the promotion flag on the next edge and restarts the wait count, so a new request again needs the full T blocked edges.
- R7: A DMA level of all ones preempts the core on the next edge whatever the core's level, with force-release high in the meantime.
- R8: Once the DMA owns the bus, it keeps the bus while its request stays high, whatever the core asks. When the DMA request drops, a requesting core is granted on the next edge.
- R9: A stall start pulse with kind code 0 (byte operation) holds the stall flag for 11 cycles. Code 1 (word operation) holds it for 8 cycles. Code 2 (one word of a block program) holds it for 3 cycles. Code 3 (block erase) holds it for 127 cycles.
- R10: A stall always ends after its programmed length, even if the DMA is granted during it. A stall start pulse while a stall is running is ignored.
- R11: A running stall counts as core activity: the core keeps its grant through the stall even with its request low. A waiting lower-level DMA is granted one edge after the stall flag falls.
- R12: The waiting flag is high exactly when the DMA requests while the core holds the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 1 | Core wants or is using the bus |
| core_prio | input | PRIO_W | Core priority level |
| dma_req | input | 1 | DMA wants or is using the bus |
| dma_prio | input | PRIO_W | DMA priority level; all ones wins always |
| wait_limit | input | WAIT_W | Blocked cycles before promotion; 0 disables |
| stall_go | input | 1 | Start pulse of a memory-controller stall |
| stall_kind | input | 2 | Stall kind: 0 byte, 1 word, 2 block word, 3 block erase |
| gnt_core | output | 1 | Core owns the bus |
| gnt_dma | output | 1 | DMA owns the bus |
| force_rel | output | 1 | Core must release the bus at the next edge |
| dma_promoted | output | 1 | Waiting DMA request has been promoted |
| core_stalled | output | 1 | Stall in progress |
| dma_waiting | output | 1 | DMA blocked behind the core |

## Verification
The bench builds the block with 2-bit priority levels and a 4-bit wait limit, keeping the default stall lengths. With these values it can sweep all sixteen priority pairs, both from an idle bus and against a core that already holds the bus. It also sweeps every wait limit from 1 to 15 and measures the exact grant edge for each. The narrow limit keeps a full sweep short, while the real stall lengths, including the 127-cycle erase, are counted cycle for cycle.

// File: rtl/arb_pkg.sv
// Package: shared types of the core/DMA bus arbiter.
// Assumes: nothing; pure type definitions.
package arb_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CORE = 2'd1,
        OWN_DMA  = 2'd2
    } owner_e;

    typedef enum logic [1:0] {
        STK_BYTE     = 2'd0,
        STK_WORD     = 2'd1,
        STK_BLKWORD  = 2'd2,
        STK_BLKERASE = 2'd3
    } stall_kind_e;
endpackage

// File: rtl/arb_stall_timer.sv
// Module: arb_stall_timer
// Loads a down-counter with a length chosen by the stall kind and holds
// the stall flag until it reaches zero. It ignores new starts while busy.
// Assumes: every length is at least 1.
module arb_stall_timer #(
    parameter int BYTE_CYC  = 11,
    parameter int WORD_CYC  = 8,
    parameter int BLKW_CYC  = 3,
    parameter int BLKE_CYC  = 127
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stall_go,
    input  logic [1:0] stall_kind,
    output logic       stalled
);
    import arb_pkg::*;

    localparam int MAX_AB = (BYTE_CYC > WORD_CYC) ? BYTE_CYC : WORD_CYC;
    localparam int MAX_CD = (BLKW_CYC > BLKE_CYC) ? BLKW_CYC : BLKE_CYC;
    localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW     = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] load_val;

    // Select the stall length for the requested operation kind.
    always_comb begin
        case (stall_kind_e'(stall_kind))
            STK_BYTE:     load_val = CW'(BYTE_CYC);
            STK_WORD:     load_val = CW'(WORD_CYC);
            STK_BLKWORD:  load_val = CW'(BLKW_CYC);
            default:      load_val = CW'(BLKE_CYC);
        endcase
    end

    // Load on a start from idle, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
        else if (stall_go)
            cnt_q <= load_val;
    end

    assign stalled = (cnt_q != '0);

    assert_stall_progress_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    assert_stall_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAXC));
endmodule

// File: rtl/arb_wait_timer.sv
// Module: arb_wait_timer
// Counts the cycles a DMA request spends blocked behind the core and
// raises the promotion flag when the programmed limit is reached.
// Assumes: a limit of zero disables promotion.
module arb_wait_timer #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_req,
    input  logic              blocked,
    input  logic              granted,
    input  logic [WAIT_W-1:0] wait_limit,
    output logic              promoted
);
    logic [WAIT_W-1:0] cnt_q;
    logic              prom_q;
    logic [WAIT_W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt_q} + 1'b1;

    // Track blocked cycles; clear on release or grant; promote at limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            prom_q <= 1'b0;
        end else if (!dma_req) begin
            cnt_q  <= '0;
            prom_q <= 1'b0;
        end else if (granted) begin
            cnt_q  <= '0;
        end else if (blocked && !prom_q && (wait_limit != '0)) begin
            if (cnt_next >= {1'b0, wait_limit}) begin
                cnt_q  <= '0;
                prom_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_next[WAIT_W-1:0];
            end
        end
    end

    assign promoted = prom_q;

    assert_no_promote_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_limit == '0 && !prom_q) |=> !prom_q);
    assert_promote_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_req |=> !prom_q);
endmodule

// File: rtl/arb_grant_fsm.sv
// Module: arb_grant_fsm
// Holds the bus owner and decides ownership changes. The owner keeps the
// bus while active; the DMA may take it from the core only through
// force-release.
// Assumes: core_active already folds in any running stall.
module arb_grant_fsm #(
    parameter int PRIO_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_active,
    input  logic              dma_req,
    input  logic [PRIO_W-1:0] core_prio,
    input  logic [PRIO_W-1:0] dma_prio,
    input  logic              promoted,
    output logic              gnt_core,
    output logic              gnt_dma,
    output logic              force_rel
);
    import arb_pkg::*;

    localparam logic [PRIO_W-1:0] TOP_PRIO = '1;

    owner_e owner_q, owner_d, pick;
    logic   dma_wins;

    // Decide whether the DMA outranks the core this cycle.
    always_comb begin
        dma_wins = promoted || (dma_prio == TOP_PRIO) || (dma_prio > core_prio);
    end

    // Arbitration result for a free bus.
    always_comb begin
        if (dma_req && (dma_wins || !core_active))
            pick = OWN_DMA;
        else if (core_active)
            pick = OWN_CORE;
        else
            pick = OWN_NONE;
    end

    assign force_rel = (owner_q == OWN_CORE) && dma_req && dma_wins;

    // Next owner: keep while active, re-arbitrate when idle or forced.
    always_comb begin
        case (owner_q)
            OWN_CORE: owner_d = force_rel ? OWN_DMA : (core_active ? OWN_CORE : pick);
            OWN_DMA:  owner_d = dma_req ? OWN_DMA : pick;
            default:  owner_d = pick;
        endcase
    end

    // Owner register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            owner_q <= OWN_NONE;
        else
            owner_q <= owner_d;
    end

    assign gnt_core = (owner_q == OWN_CORE);
    assign gnt_dma  = (owner_q == OWN_DMA);

    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_core, gnt_dma}));
    assert_force_hands_over_R3: assert property (@(posedge clk) disable iff (!rst_n)
        force_rel |=> gnt_dma);
    assert_dma_keeps_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_dma && dma_req) |=> gnt_dma);
    assert_core_keeps_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_core && core_active && !force_rel) |=> gnt_core);
endmodule

// File: rtl/core_dma_arbiter.sv
// Module: core_dma_arbiter (top)
// Shares one bus between the core and a DMA engine, using priority
// levels, wait-limit promotion of blocked DMA requests and a
// memory-controller stall timer that keeps the core active.
// Assumes: requests stay high for as long as the requester uses the bus.
module core_dma_arbiter #(
    parameter int PRIO_W   = 2,
    parameter int WAIT_W   = 8,
    parameter int BYTE_CYC = 11,
    parameter int WORD_CYC = 8,
    parameter int BLKW_CYC = 3,
    parameter int BLKE_CYC = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic [PRIO_W-1:0] core_prio,
    input  logic              dma_req,
    input  logic [PRIO_W-1:0] dma_prio,
    input  logic [WAIT_W-1:0] wait_limit,
    input  logic              stall_go,
    input  logic [1:0]        stall_kind,
    output logic              gnt_core,
    output logic              gnt_dma,
    output logic              force_rel,
    output logic              dma_promoted,
    output logic              core_stalled,
    output logic              dma_waiting
);
    logic core_active;
    logic blocked;

    arb_stall_timer #(
        .BYTE_CYC(BYTE_CYC), .WORD_CYC(WORD_CYC),
        .BLKW_CYC(BLKW_CYC), .BLKE_CYC(BLKE_CYC)
    ) u_stall (
        .clk(clk), .rst_n(rst_n), .stall_go(stall_go),
        .stall_kind(stall_kind), .stalled(core_stalled)
    );

    assign core_active = core_req | core_stalled;
    assign blocked     = dma_req & gnt_core;
    assign dma_waiting = blocked;

    arb_wait_timer #(.WAIT_W(WAIT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .blocked(blocked),
        .granted(gnt_dma), .wait_limit(wait_limit), .promoted(dma_promoted)
    );

    arb_grant_fsm #(.PRIO_W(PRIO_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .core_active(core_active),
        .dma_req(dma_req), .core_prio(core_prio), .dma_prio(dma_prio),
        .promoted(dma_promoted), .gnt_core(gnt_core), .gnt_dma(gnt_dma),
        .force_rel(force_rel)
    );

    assert_force_only_when_core_owns_R3: assert property (@(posedge clk) disable iff (!rst_n)
        force_rel |-> (gnt_core && dma_req));
endmodule

// File: tb/tb_core_dma_arbiter.sv
// Bench: sweeps priority pairs and wait limits, and counts stall lengths.
module tb_core_dma_arbiter;
    localparam int PW = 2;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          core_req = 1'b0, dma_req = 1'b0, stall_go = 1'b0;
    logic [PW-1:0] core_prio = '0, dma_prio = '0;
    logic [WW-1:0] wait_limit = '0;
    logic [1:0]    stall_kind = '0;
    logic gnt_core, gnt_dma, force_rel, dma_promoted, core_stalled, dma_waiting;

    int nchk = 0;
    int nfail = 0;

    core_dma_arbiter #(.PRIO_W(PW), .WAIT_W(WW)) dut (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_prio(core_prio),
        .dma_req(dma_req), .dma_prio(dma_prio), .wait_limit(wait_limit),
        .stall_go(stall_go), .stall_kind(stall_kind), .gnt_core(gnt_core),
        .gnt_dma(gnt_dma), .force_rel(force_rel), .dma_promoted(dma_promoted),
        .core_stalled(core_stalled), .dma_waiting(dma_waiting)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_idle();
        core_req = 1'b0;
        dma_req  = 1'b0;
        repeat (3) step();
    endtask

    task automatic wait_dma(output int n, input int lim);
        n = 0;
        do begin
            step();
            n++;
        end while (!gnt_dma && n < lim);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int n;
        int win;
        int esc_at;
        repeat (3) step();
        // R1 reset state
        check("R1 reset grants", {gnt_core, gnt_dma}, 0);
        check("R1 reset flags", {force_rel, dma_promoted, core_stalled, dma_waiting}, 0);
        rst_n = 1'b1;
        step();

        // R2 simultaneous requests on an idle bus
        for (int cp = 0; cp < 4; cp++) begin
            for (int dp = 0; dp < 4; dp++) begin
                core_prio = PW'(cp); dma_prio = PW'(dp);
                core_req = 1'b1; dma_req = 1'b1;
                step();
                win = (dp > cp || dp == 3) ? 1 : 0;
                check("R2 idle arbitration dma", gnt_dma, win);
                check("R1 R2 idle arbitration core", gnt_core, 1 - win);
                go_idle();
            end
        end

        // R3 R5 R7 R12 core owns, DMA arrives, limit 5
        wait_limit = WW'(5);
        for (int cp = 0; cp < 4; cp++) begin
            for (int dp = 0; dp < 4; dp++) begin
                core_prio = PW'(cp); dma_prio = PW'(dp);
                core_req = 1'b1;
                repeat (2) step();
                dma_req = 1'b1;
                #1;
                win = (dp > cp || dp == 3) ? 1 : 0;
                check("R3 R7 force_rel", force_rel, win);
                check("R12 waiting flag", dma_waiting, 1);
                wait_dma(n, 30);
                check("R3 R5 R7 grant edge", n, win ? 1 : 6);
                check("R1 core dropped", gnt_core, 0);
                go_idle();
            end
        end

        // R4 limit zero: lower DMA waits for core idle
        wait_limit = '0;
        for (int cp = 0; cp < 4; cp++) begin
            for (int dp = 0; dp <= cp && dp < 3; dp++) begin
                core_prio = PW'(cp); dma_prio = PW'(dp);
                core_req = 1'b1;
                repeat (2) step();
                dma_req = 1'b1;
                wait_dma(n, 20);
                check("R4 no grant while core busy", gnt_dma, 0);
                check("R4 no promotion", dma_promoted, 0);
                core_req = 1'b0;
                step();
                check("R4 grant after core idle", gnt_dma, 1);
                go_idle();
            end
        end

        // R5 sweep of wait limit
        core_prio = 2'd2; dma_prio = 2'd1;
        for (int t = 1; t < 16; t++) begin
            wait_limit = WW'(t);
            core_req = 1'b1;
            repeat (2) step();
            dma_req = 1'b1;
            n = 0; esc_at = 0;
            do begin
                step();
                n++;
                if (dma_promoted && esc_at == 0) esc_at = n;
            end while (!gnt_dma && n < 40);
            check("R5 promotion edge", esc_at, t);
            check("R5 grant edge", n, t + 1);
            go_idle();
        end

        // R6 drop before limit restarts the count; flag clears after release
        wait_limit = WW'(6);
        core_req = 1'b1;
        repeat (2) step();
        dma_req = 1'b1;
        repeat (3) step();
        dma_req = 1'b0;
        step();
        dma_req = 1'b1;
        wait_dma(n, 30);
        check("R6 full wait after restart", n, 7);
        check("R6 promoted during transfer", dma_promoted, 1);
        dma_req = 1'b0;
        step();
        check("R6 promotion cleared", dma_promoted, 0);
        go_idle();

        // R8 DMA keeps bus against top core level
        wait_limit = '0; dma_prio = 2'd3; core_prio = 2'd3;
        dma_req = 1'b1;
        step();
        core_req = 1'b1;
        n = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            n += gnt_dma;
        end
        check("R8 dma holds bus", n, 10);
        dma_req = 1'b0;
        step();
        check("R8 core granted after release", gnt_core, 1);
        go_idle();

        // R9 stall lengths per kind
        for (int k = 0; k < 4; k++) begin
            stall_kind = 2'(k);
            stall_go = 1'b1;
            step();
            stall_go = 1'b0;
            n = 0;
            while (core_stalled && n < 300) begin
                n++;
                step();
            end
            check("R9 stall length", n, (k == 0) ? 11 : (k == 1) ? 8 : (k == 2) ? 3 : 127);
            go_idle();
        end

        // R10 restart ignored while stalled
        stall_kind = 2'd0; stall_go = 1'b1;
        step();
        stall_go = 1'b0;
        n = 1;
        repeat (4) begin step(); n++; end
        stall_kind = 2'd3; stall_go = 1'b1;
        step(); n++;
        stall_go = 1'b0;
        while (core_stalled && n < 300) begin
            step();
            if (core_stalled) n++;
        end
        check("R10 restart ignored", n, 11);
        go_idle();

        // R10 stall ends although DMA is granted in the middle
        stall_kind = 2'd3; stall_go = 1'b1; dma_prio = 2'd3;
        step();
        stall_go = 1'b0;
        n = 0;
        while (core_stalled && n < 300) begin
            n++;
            if (n == 4) dma_req = 1'b1;
            step();
        end
        check("R10 stall terminates under dma", n, 127);
        check("R10 dma owns at stall end", gnt_dma, 1);
        go_idle();

        // R11 stall keeps core granted with core_req low
        core_prio = 2'd3; dma_prio = 2'd0; wait_limit = '0;
        stall_kind = 2'd0; stall_go = 1'b1;
        step();
        stall_go = 1'b0;
        step();
        check("R11 core granted by stall", gnt_core, 1);
        dma_req = 1'b1;
        while (core_stalled) step();
        check("R11 core holds at stall end", gnt_core, 1);
        step();
        check("R11 dma after stall", gnt_dma, 1);
        go_idle();

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule